// File: doc/BRIEF.md
# Directory Writeback Completion Tracker

This block sits on the directory side of a coherence controller. It tracks a small set of lines through the transient period that follows a writeback to memory. A dirty writeback or a full-line DMA write puts the line into a waiting state. The block then issues the memory writeback, stores a copy of the written data in a per-line buffer, and records what is still outstanding. That can be the memory's write acknowledgement, the unblock that follows a DMA acknowledgement, or both.

A line that only waits for the memory acknowledgement returns to its stable state as soon as that acknowledgement arrives. A line that waits on both keeps two independent pending flags. Each clearing event runs a completion check. When both flags are clear, the check posts the line number into a small internal trigger FIFO. The trigger FIFO is served before the event input. A popped trigger retires the line to invalid, frees its buffer and drops the directory entry.

While a line is transient, new requests for it are recycled and not serviced. A functional read port returns the buffered copy when the memory write for that line is still outstanding. A functional write port updates the buffer when the line is transient.

Top module: `wb_done_tracker`

## Requirements
- R1: After a synchronous active-low reset every line reads state 0 (invalid), `ev_ready` is 1 and every output pulse is 0.
- R2: A dirty writeback (`ev_kind`=0) with `ev_keep_shr`=0 on a stable line moves it to state 2 (writeback, will be invalid). In the next cycle the block pulses `mem_wb_valid` with that line and data. It also buffers the data with the writeback-pending flag set.
- R3: A dirty writeback with `ev_keep_shr`=1 on a stable line moves it to state 3 (writeback, will be shared) and issues the memory writeback in the same way.
- R4: A memory ack (`ev_kind`=2) in state 2 moves the line to state 0 and pulses `dir_drop_valid` for it. In state 3 it moves the line to state 1 (shared) without a drop pulse.
- R5: A DMA full-line write (`ev_kind`=1) on a stable line moves it to state 4 (waiting for DMA unblock). It sets both pending flags, issues the memory writeback, and pulses `dma_ack_valid` carrying `ev_shr_cnt`, all in the same cycle.
- R6: In state 4, a memory ack and an exclusive unblock (`ev_kind`=3) each clear their own flag, in either order. The line leaves state 4 only one cycle after the second of them. It then goes to state 0 with a `dir_drop_valid` pulse.
- R7: While a completion trigger is pending, `ev_ready` is 0, so the trigger is served ahead of any event.
- R8: A dirty writeback or DMA write to a line in states 2 to 4 pulses `recycle_valid` with the line. It changes neither the line's state nor its buffered data, and issues no memory writeback.
- R9: A memory ack to a line whose writeback flag is clear, or an exclusive unblock to a line not in state 4 or whose DMA flag is clear, pulses `proto_err` and changes no state.
- R10: A functional write updates the buffered data of a line in states 2 to 4. On a stable line it has no effect on the line's state or on the functional read result.
- R11: `fr_from_buf` is 1, and `fr_data` shows the buffered data, exactly when the addressed line is in states 2 to 4 with its writeback flag still set. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle (low while a trigger is pending) |
| ev_kind | input | 2 | 0 dirty writeback, 1 DMA line write, 2 memory ack, 3 exclusive unblock |
| ev_line | input | LINE_W | Line the event addresses |
| ev_keep_shr | input | 1 | Dirty writeback returns to shared rather than invalid |
| ev_data | input | DATA_W | Write data carried by a writeback or DMA write |
| ev_shr_cnt | input | CNT_W | Current sharer count for the DMA acknowledgement |
| mem_wb_valid | output | 1 | Memory writeback issued |
| mem_wb_line | output | LINE_W | Line of the memory writeback |
| mem_wb_data | output | DATA_W | Data of the memory writeback |
| dma_ack_valid | output | 1 | DMA acknowledgement issued |
| dma_ack_line | output | LINE_W | Line of the DMA acknowledgement |
| dma_ack_cnt | output | CNT_W | Sharer count carried by the acknowledgement |
| recycle_valid | output | 1 | Request recycled, not serviced |
| recycle_line | output | LINE_W | Line of the recycled request |
| dir_drop_valid | output | 1 | Directory entry dropped, line now invalid |
| dir_drop_line | output | LINE_W | Line whose entry is dropped |
| proto_err | output | 1 | Protocol error pulse |
| fr_line | input | LINE_W | Functional read line |
| fr_state | output | 3 | State of the read line |
| fr_from_buf | output | 1 | Read served from the buffer |
| fr_data | output | DATA_W | Buffered data, 0 when not served from the buffer |
| fw_valid | input | 1 | Functional write strobe |
| fw_line | input | LINE_W | Functional write line |
| fw_data | input | DATA_W | Functional write data |

## Verification
Every event result is registered. The writeback, acknowledgement, recycle, error and immediate drop pulses, and the new line state, all appear one cycle after the edge that accepts the event. A retirement through the trigger appears one cycle later still, while `ev_ready` is low. The functional read outputs follow `fr_line` within the same cycle. The bench drives inputs just after a rising edge. It updates a behavioural model on that edge and compares all outputs at the falling edge, so each result is checked in exactly the cycle it is due. Directed checks after each scenario sample one cycle after acceptance, and again one cycle later for the retirement.

// File: rtl/wbt_pkg.sv
// Package: shared types for the writeback completion tracker.
// Assumes: event and state codes are fixed by the port-level contract.
package wbt_pkg;

    typedef enum logic [1:0] {
        EV_DIRTY_WB = 2'd0,
        EV_DMA_WR   = 2'd1,
        EV_MEM_ACK  = 2'd2,
        EV_UNBLK    = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        LS_INV      = 3'd0,
        LS_SHR      = 3'd1,
        LS_WB_INV   = 3'd2,
        LS_WB_SHR   = 3'd3,
        LS_DMA_WAIT = 3'd4
    } line_st_e;

    // A line is transient (holds a buffer entry) in the three waiting states.
    function automatic logic is_transient(line_st_e st);
        return (st == LS_WB_INV) || (st == LS_WB_SHR) || (st == LS_DMA_WAIT);
    endfunction

endpackage

// File: rtl/wbt_trig_fifo.sv
// Module: small circular FIFO of line numbers for self-posted completion triggers.
// Assumes: the caller never pushes when full and never pops when empty.
module wbt_trig_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/wbt_line_slot.sv
// Module: state, pending flags and data buffer of one tracked line.
// Assumes: the top validates every command; at most one of alloc, ack,
// unblk and retire is asserted per cycle.
module wbt_line_slot
    import wbt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_alloc,
    input  line_st_e          alloc_st,
    input  logic              alloc_dma,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              do_ack,
    input  logic              do_unblk,
    input  logic              do_retire,
    input  logic              fw_hit,
    input  logic [DATA_W-1:0] fw_data,
    output line_st_e          st,
    output logic              wb_pend,
    output logic              dma_pend,
    output logic [DATA_W-1:0] data
);
    // State and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LS_INV;
            wb_pend  <= 1'b0;
            dma_pend <= 1'b0;
        end else if (do_alloc) begin
            st       <= alloc_st;
            wb_pend  <= 1'b1;
            dma_pend <= alloc_dma;
        end else if (do_ack) begin
            wb_pend <= 1'b0;
            if (st == LS_WB_INV)      st <= LS_INV;
            else if (st == LS_WB_SHR) st <= LS_SHR;
        end else if (do_unblk) begin
            dma_pend <= 1'b0;
        end else if (do_retire) begin
            st <= LS_INV;
        end
    end

    // Buffer data: allocation wins over a functional write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (do_alloc) begin
            data <= alloc_data;
        end else if (fw_hit) begin
            data <= fw_data;
        end
    end
endmodule

// File: rtl/wb_done_tracker.sv
// Module: directory writeback completion tracker (top).
// Decodes events against the addressed line, issues writebacks and DMA
// acknowledgements, joins the two pending flags through a trigger FIFO, and
// serves functional reads and writes.
// Assumes: events are presented with ev_valid and taken when ev_ready is high.
module wb_done_tracker
    import wbt_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 4,
    parameter int TRIG_DEPTH = 4,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [1:0]        ev_kind,
    input  logic [LINE_W-1:0] ev_line,
    input  logic              ev_keep_shr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [CNT_W-1:0]  ev_shr_cnt,
    output logic              mem_wb_valid,
    output logic [LINE_W-1:0] mem_wb_line,
    output logic [DATA_W-1:0] mem_wb_data,
    output logic              dma_ack_valid,
    output logic [LINE_W-1:0] dma_ack_line,
    output logic [CNT_W-1:0]  dma_ack_cnt,
    output logic              recycle_valid,
    output logic [LINE_W-1:0] recycle_line,
    output logic              dir_drop_valid,
    output logic [LINE_W-1:0] dir_drop_line,
    output logic              proto_err,
    input  logic [LINE_W-1:0] fr_line,
    output logic [2:0]        fr_state,
    output logic              fr_from_buf,
    output logic [DATA_W-1:0] fr_data,
    input  logic              fw_valid,
    input  logic [LINE_W-1:0] fw_line,
    input  logic [DATA_W-1:0] fw_data
);
    line_st_e          slot_st   [NUM_LINES];
    logic              slot_wb   [NUM_LINES];
    logic              slot_dma  [NUM_LINES];
    logic [DATA_W-1:0] slot_data [NUM_LINES];

    ev_kind_e kind;
    logic     accept, is_req, sel_busy;
    line_st_e sel_st, alloc_st, trig_st;
    logic     sel_wb, sel_dma;
    logic     do_alloc, do_recycle, ack_ok, unb_ok, ev_err;
    logic     trig_push, trig_pop, trig_empty, trig_full;
    logic     retire_ok, trig_err, drop_now;
    logic [LINE_W-1:0] trig_line, push_line, drop_line_c;

    // Decode the presented event against the addressed line.
    always_comb begin
        kind       = ev_kind_e'(ev_kind);
        accept     = ev_valid && ev_ready;
        sel_st     = slot_st[ev_line];
        sel_wb     = slot_wb[ev_line];
        sel_dma    = slot_dma[ev_line];
        sel_busy   = is_transient(sel_st);
        is_req     = (kind == EV_DIRTY_WB) || (kind == EV_DMA_WR);
        do_recycle = accept && is_req && sel_busy;
        do_alloc   = accept && is_req && !sel_busy;
        alloc_st   = (kind == EV_DMA_WR) ? LS_DMA_WAIT :
                     (ev_keep_shr ? LS_WB_SHR : LS_WB_INV);
        ack_ok     = accept && (kind == EV_MEM_ACK) && sel_busy && sel_wb;
        unb_ok     = accept && (kind == EV_UNBLK) && (sel_st == LS_DMA_WAIT) && sel_dma;
        ev_err     = accept && (((kind == EV_MEM_ACK) && !ack_ok) ||
                                ((kind == EV_UNBLK) && !unb_ok));
    end

    // Completion check: post a trigger when the event clears the last flag.
    always_comb begin
        trig_push = (ack_ok && (sel_st == LS_DMA_WAIT) && !sel_dma) ||
                    (unb_ok && !sel_wb);
        push_line = ev_line;
    end

    // Trigger service: retire only a DMA-wait line with both flags clear.
    always_comb begin
        trig_pop    = !trig_empty;
        trig_st     = slot_st[trig_line];
        retire_ok   = trig_pop && (trig_st == LS_DMA_WAIT) &&
                      !slot_wb[trig_line] && !slot_dma[trig_line];
        trig_err    = trig_pop && !retire_ok;
        drop_now    = retire_ok || (ack_ok && (sel_st == LS_WB_INV));
        drop_line_c = retire_ok ? trig_line : ev_line;
    end

    assign ev_ready = trig_empty;

    wbt_trig_fifo #(
        .DEPTH (TRIG_DEPTH),
        .W     (LINE_W)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (trig_push),
        .push_data (push_line),
        .pop       (trig_pop),
        .pop_data  (trig_line),
        .empty     (trig_empty),
        .full      (trig_full)
    );

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_slot
        logic hit_ev, hit_trig, hit_fw;
        assign hit_ev   = (ev_line == LINE_W'(gi));
        assign hit_trig = (trig_line == LINE_W'(gi));
        assign hit_fw   = fw_valid && (fw_line == LINE_W'(gi)) && is_transient(slot_st[gi]);

        wbt_line_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_alloc   (do_alloc && hit_ev),
            .alloc_st   (alloc_st),
            .alloc_dma  (kind == EV_DMA_WR),
            .alloc_data (ev_data),
            .do_ack     (ack_ok && hit_ev),
            .do_unblk   (unb_ok && hit_ev),
            .do_retire  (retire_ok && hit_trig),
            .fw_hit     (hit_fw),
            .fw_data    (fw_data),
            .st         (slot_st[gi]),
            .wb_pend    (slot_wb[gi]),
            .dma_pend   (slot_dma[gi]),
            .data       (slot_data[gi])
        );
    end

    // Registered message outputs, one cycle after the deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wb_valid   <= 1'b0;
            mem_wb_line    <= '0;
            mem_wb_data    <= '0;
            dma_ack_valid  <= 1'b0;
            dma_ack_line   <= '0;
            dma_ack_cnt    <= '0;
            recycle_valid  <= 1'b0;
            recycle_line   <= '0;
            dir_drop_valid <= 1'b0;
            dir_drop_line  <= '0;
            proto_err      <= 1'b0;
        end else begin
            mem_wb_valid   <= do_alloc;
            dma_ack_valid  <= do_alloc && (kind == EV_DMA_WR);
            recycle_valid  <= do_recycle;
            dir_drop_valid <= drop_now;
            proto_err      <= ev_err || trig_err;
            if (do_alloc) begin
                mem_wb_line  <= ev_line;
                mem_wb_data  <= ev_data;
                dma_ack_line <= ev_line;
                dma_ack_cnt  <= ev_shr_cnt;
            end
            if (do_recycle) recycle_line  <= ev_line;
            if (drop_now)   dir_drop_line <= drop_line_c;
        end
    end

    // Functional read: buffer only while the memory write is outstanding.
    always_comb begin
        fr_state    = slot_st[fr_line];
        fr_from_buf = is_transient(slot_st[fr_line]) && slot_wb[fr_line];
        fr_data     = fr_from_buf ? slot_data[fr_line] : '0;
    end
endmodule

// File: rtl/wbt_checker.sv
// Module: protocol assertions for the writeback completion tracker, bound
// to the top. Assumes: signal names of the top as connected below.
module wbt_checker #(
    parameter int LINE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_push,
    input logic              trig_full,
    input logic              ev_ready,
    input logic              mem_wb_valid,
    input logic [LINE_W-1:0] mem_wb_line,
    input logic              dma_ack_valid,
    input logic [LINE_W-1:0] dma_ack_line,
    input logic              recycle_valid,
    input logic              proto_err
);
    // R7: the trigger FIFO never receives a push when full.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_full |-> !trig_push);

    // R7: a posted trigger blocks the event input in the next cycle.
    p_trig_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_push |=> !ev_ready);

    // R5: every DMA acknowledgement comes with a writeback of the same line.
    p_dma_with_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack_valid |-> (mem_wb_valid && (mem_wb_line == dma_ack_line)));

    // R8: a recycled request never issues a memory writeback.
    p_recycle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recycle_valid |-> !mem_wb_valid);

    // R9: a protocol error never coincides with a new writeback.
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!mem_wb_valid && !dma_ack_valid));
endmodule

bind wb_done_tracker wbt_checker #(
    .LINE_W (LINE_W)
) u_wbt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_push     (trig_push),
    .trig_full     (trig_full),
    .ev_ready      (ev_ready),
    .mem_wb_valid  (mem_wb_valid),
    .mem_wb_line   (mem_wb_line),
    .dma_ack_valid (dma_ack_valid),
    .dma_ack_line  (dma_ack_line),
    .recycle_valid (recycle_valid),
    .proto_err     (proto_err)
);

// File: tb/wb_done_tracker_tb_top.sv
// Bench: behavioural reference model compared at every falling edge, plus
// directed checks after each scenario.
module wb_done_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic ev_ready;
    logic [1:0] ev_kind = '0;
    logic [LW-1:0] ev_line = '0;
    logic ev_keep_shr = 1'b0;
    logic [DW-1:0] ev_data = '0;
    logic [CW-1:0] ev_shr_cnt = '0;
    logic mem_wb_valid, dma_ack_valid, recycle_valid, dir_drop_valid, proto_err;
    logic [LW-1:0] mem_wb_line, dma_ack_line, recycle_line, dir_drop_line;
    logic [DW-1:0] mem_wb_data, fr_data;
    logic [CW-1:0] dma_ack_cnt;
    logic [LW-1:0] fr_line = '0;
    logic [2:0] fr_state;
    logic fr_from_buf;
    logic fw_valid = 1'b0;
    logic [LW-1:0] fw_line = '0;
    logic [DW-1:0] fw_data = '0;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_done_tracker #(.NUM_LINES(NL), .DATA_W(DW), .CNT_W(CW), .TRIG_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_line(ev_line), .ev_keep_shr(ev_keep_shr),
        .ev_data(ev_data), .ev_shr_cnt(ev_shr_cnt),
        .mem_wb_valid(mem_wb_valid), .mem_wb_line(mem_wb_line), .mem_wb_data(mem_wb_data),
        .dma_ack_valid(dma_ack_valid), .dma_ack_line(dma_ack_line), .dma_ack_cnt(dma_ack_cnt),
        .recycle_valid(recycle_valid), .recycle_line(recycle_line),
        .dir_drop_valid(dir_drop_valid), .dir_drop_line(dir_drop_line),
        .proto_err(proto_err), .fr_line(fr_line), .fr_state(fr_state),
        .fr_from_buf(fr_from_buf), .fr_data(fr_data),
        .fw_valid(fw_valid), .fw_line(fw_line), .fw_data(fw_data)
    );

    // Reference model state.
    int m_st [NL];
    bit m_wb [NL];
    bit m_dm [NL];
    logic [DW-1:0] m_dat [NL];
    int trig_q[$];
    bit e_wb, e_dma, e_rec, e_drop, e_err;
    int e_wb_line, e_dma_line, e_rec_line, e_drop_line;
    logic [DW-1:0] e_wb_data;
    logic [CW-1:0] e_dma_cnt;

    function automatic bit trans(int s);
        return (s >= 2) && (s <= 4);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on the rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                m_st[i] = 0; m_wb[i] = 0; m_dm[i] = 0; m_dat[i] = '0;
            end
            trig_q.delete();
            e_wb = 0; e_dma = 0; e_rec = 0; e_drop = 0; e_err = 0;
        end else begin
            int l;
            e_wb = 0; e_dma = 0; e_rec = 0; e_drop = 0; e_err = 0;
            if (fw_valid && trans(m_st[fw_line])) m_dat[fw_line] = fw_data;
            if (trig_q.size() > 0) begin
                l = trig_q.pop_front();
                if (m_st[l] == 4 && !m_wb[l] && !m_dm[l]) begin
                    m_st[l] = 0; e_drop = 1; e_drop_line = l;
                end else e_err = 1;
            end else if (ev_valid) begin
                l = int'(ev_line);
                case (ev_kind)
                    2'd0, 2'd1: begin
                        if (trans(m_st[l])) begin
                            e_rec = 1; e_rec_line = l;
                        end else begin
                            m_st[l] = (ev_kind == 2'd1) ? 4 : (ev_keep_shr ? 3 : 2);
                            m_wb[l] = 1; m_dm[l] = (ev_kind == 2'd1);
                            m_dat[l] = ev_data;
                            e_wb = 1; e_wb_line = l; e_wb_data = ev_data;
                            if (ev_kind == 2'd1) begin
                                e_dma = 1; e_dma_line = l; e_dma_cnt = ev_shr_cnt;
                            end
                        end
                    end
                    2'd2: begin
                        if (trans(m_st[l]) && m_wb[l]) begin
                            m_wb[l] = 0;
                            if (m_st[l] == 2) begin
                                m_st[l] = 0; e_drop = 1; e_drop_line = l;
                            end else if (m_st[l] == 3) m_st[l] = 1;
                            else if (!m_dm[l]) trig_q.push_back(l);
                        end else e_err = 1;
                    end
                    default: begin
                        if (m_st[l] == 4 && m_dm[l]) begin
                            m_dm[l] = 0;
                            if (!m_wb[l]) trig_q.push_back(l);
                        end else e_err = 1;
                    end
                endcase
            end
        end
    end

    // Cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            bit fb;
            fb = trans(m_st[fr_line]) && m_wb[fr_line];
            chk("R7", "ev_ready", ev_ready, trig_q.size() == 0);
            chk("R2", "mem_wb_valid", mem_wb_valid, e_wb);
            if (e_wb) begin
                chk("R2", "mem_wb_line", mem_wb_line, e_wb_line);
                chk("R2", "mem_wb_data", mem_wb_data, e_wb_data);
            end
            chk("R5", "dma_ack_valid", dma_ack_valid, e_dma);
            if (e_dma) begin
                chk("R5", "dma_ack_line", dma_ack_line, e_dma_line);
                chk("R5", "dma_ack_cnt", dma_ack_cnt, e_dma_cnt);
            end
            chk("R8", "recycle_valid", recycle_valid, e_rec);
            if (e_rec) chk("R8", "recycle_line", recycle_line, e_rec_line);
            chk("R4", "dir_drop_valid", dir_drop_valid, e_drop);
            if (e_drop) chk("R6", "dir_drop_line", dir_drop_line, e_drop_line);
            chk("R9", "proto_err", proto_err, e_err);
            chk("R6", "fr_state", fr_state, m_st[fr_line]);
            chk("R11", "fr_from_buf", fr_from_buf, fb);
            chk("R11", "fr_data", fr_data, fb ? m_dat[fr_line] : 0);
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send(int kind, int line, bit keep, logic [DW-1:0] data, int cnt);
        while (!ev_ready) step(1);
        ev_valid = 1; ev_kind = 2'(kind); ev_line = LW'(line);
        ev_keep_shr = keep; ev_data = data; ev_shr_cnt = CW'(cnt);
        step(1);
        ev_valid = 0;
    endtask

    task automatic look(int line);
        fr_line = LW'(line);
        #1;
    endtask

    initial begin
        rst_n = 0;
        step(3);
        rst_n = 1;
        cmp_en = 1;
        step(1);
        // R1: reset state
        chk("R1", "ev_ready", ev_ready, 1);
        chk("R1", "pulses", {mem_wb_valid, dma_ack_valid, recycle_valid, dir_drop_valid, proto_err}, 0);
        for (int i = 0; i < NL; i++) begin
            look(i);
            chk("R1", "state", fr_state, 0);
        end
        // R2: dirty writeback to invalid
        send(0, 1, 0, 32'hA5A5_0001, 0);
        look(1);
        chk("R2", "state", fr_state, 2);
        chk("R2", "wb pulse", mem_wb_valid, 1);
        chk("R11", "buf data", fr_data, 32'hA5A5_0001);
        // R8: request to busy line recycled, data kept
        send(1, 1, 0, 32'h0BAD_0BAD, 3);
        chk("R8", "recycle", recycle_valid, 1);
        chk("R8", "no wb", mem_wb_valid, 0);
        chk("R8", "data kept", fr_data, 32'hA5A5_0001);
        chk("R8", "state kept", fr_state, 2);
        // R10: functional write to transient line
        fw_valid = 1; fw_line = 1; fw_data = 32'h1234_5678;
        step(1);
        fw_valid = 0;
        chk("R10", "fw data", fr_data, 32'h1234_5678);
        // R4: memory ack in will-be-invalid
        send(2, 1, 0, 0, 0);
        chk("R4", "state", fr_state, 0);
        chk("R4", "drop", dir_drop_valid, 1);
        chk("R11", "from_buf", fr_from_buf, 0);
        // R9: duplicate ack
        send(2, 1, 0, 0, 0);
        chk("R9", "err", proto_err, 1);
        chk("R9", "state", fr_state, 0);
        // R3: dirty writeback to shared
        send(0, 2, 1, 32'hC0DE_0002, 0);
        look(2);
        chk("R3", "state", fr_state, 3);
        send(2, 2, 0, 0, 0);
        chk("R4", "state shared", fr_state, 1);
        chk("R4", "no drop", dir_drop_valid, 0);
        // R10: functional write to stable line has no effect
        fw_valid = 1; fw_line = 2; fw_data = 32'hFFFF_0000;
        step(1);
        fw_valid = 0;
        chk("R10", "stable state", fr_state, 1);
        chk("R10", "stable from_buf", fr_from_buf, 0);
        // R5: DMA write
        send(1, 3, 0, 32'hD1A0_0003, 5);
        look(3);
        chk("R5", "state", fr_state, 4);
        chk("R5", "dma ack", dma_ack_valid, 1);
        chk("R5", "cnt", dma_ack_cnt, 5);
        // R6: unblock then ack
        send(3, 3, 0, 0, 0);
        chk("R6", "still waiting", fr_state, 4);
        chk("R6", "ready", ev_ready, 1);
        send(2, 3, 0, 0, 0);
        chk("R7", "ready low", ev_ready, 0);
        chk("R6", "not yet", fr_state, 4);
        step(1);
        chk("R6", "retired", fr_state, 0);
        chk("R6", "drop", dir_drop_valid, 1);
        chk("R6", "drop line", dir_drop_line, 3);
        // R6: ack then unblock, DMA on shared line
        send(1, 2, 0, 32'hD1A0_0004, 2);
        send(2, 2, 0, 0, 0);
        look(2);
        chk("R11", "ack cleared: memory", fr_from_buf, 0);
        chk("R6", "waiting", fr_state, 4);
        send(3, 2, 0, 0, 0);
        chk("R7", "ready low", ev_ready, 0);
        step(1);
        chk("R6", "retired", fr_state, 0);
        // R9: unblock in wrong state
        send(3, 0, 0, 0, 0);
        chk("R9", "unblock err", proto_err, 1);
        look(0);
        chk("R9", "state", fr_state, 0);
        step(3);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule